// File: doc/BRIEF.md
# Integer ALU with carry control

This block is the integer execute unit of a small load/store RISC core. Each cycle it receives a 6-bit opcode, an 11-bit function field, two 32-bit operands and the current value of the architectural carry flag. It returns the 32-bit result, the next value of the carry flag and a strobe saying whether that flag should be written. Operand B is either a register value or an immediate that the decode stage has already extended to full width, so register and immediate forms of an operation behave identically here.

The unit covers addition and reverse subtraction (B minus A), with or without the stored carry as carry-in and with or without updating the flag. It also covers signed and unsigned compares, the four bitwise operations, three one-bit right shifts that pass the carry through, and byte and halfword sign extension. The result path is combinational. When the `REG_OUT` parameter is 1 (the default), a register follows it and delays all three outputs by one clock. A control decoder turns opcode and function into a bundle of strobes, and a datapath module consumes those strobes.

Top module: `int_alu`

## Requirements
- R1: Opcodes with bits [5:4] = 00 and bit 0 = 0 add. The result is A + B + cin, where cin is `carryIn` when opcode bit 1 is set and 0 otherwise. When opcode bit 2 is clear, `carryOut` is the unsigned carry out of bit 31 and `carryWe` is 1.
- R2: Opcodes with bits [5:4] = 00 and bit 0 = 1 reverse-subtract. The result is B + ~A + cin, where cin is `carryIn` when opcode bit 1 is set and 1 otherwise. When opcode bit 2 is clear, `carryOut` is the carry out of bit 31 (1 means no borrow) and `carryWe` is 1.
- R3: For add/subtract opcodes with bit 2 set, `carryWe` is 0. Whenever `carryWe` is 0 for any operation, `carryOut` equals `carryIn`.
- R4: Opcode 000101 with function 0x001 is a signed compare. The result is B − A with bit 31 replaced by 1 when A > B as signed numbers and 0 otherwise. `carryWe` is 0.
- R5: Opcode 000101 with function 0x003 is an unsigned compare. It is the same as R4 but uses unsigned ordering. `carryWe` is 0.
- R6: Opcodes matching 10x0xx apply the operation chosen by opcode bits [1:0]: 0 = OR, 1 = AND, 2 = XOR, 3 = A AND NOT B. `carryWe` is 0.
- R7: Opcode 100100 with function 0x001, 0x021 or 0x041 shifts A right by one bit. The new top bit is A[31], `carryIn` or 0 respectively. `carryOut` is A[0] and `carryWe` is 1.
- R8: Opcode 100100 with function 0x060 sign-extends A[7:0]. With function 0x061 it sign-extends A[15:0]. `carryWe` is 0 in both cases.
- R9: Any other function value under opcode 100100, and any opcode outside the groups above, gives a zero result and `carryWe` = 0.
- R10: With `REG_OUT` = 1, the outputs show the result of the inputs sampled at the previous rising clock edge. While `rstN` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset of the output register |
| opcode | input | 6 | Operation group and modifier bits |
| func | input | 11 | Function field for compare, shift and extend |
| opA | input | 32 | Operand A |
| opB | input | 32 | Operand B, register or pre-extended immediate |
| carryIn | input | 1 | Current carry flag |
| result | output | 32 | Operation result |
| carryOut | output | 1 | Next carry flag value |
| carryWe | output | 1 | Carry flag write strobe |

## Verification
The assertions assume that the inputs are known (no X values) at every rising edge after reset. They also assume that each output reflects exactly one set of inputs sampled at one edge, so the checker keeps its own one-cycle copy of the inputs when the output register is present. The bench drives new inputs only on falling edges. It draws each operation from a pool of legal opcode and function pairs, and deliberately adds undefined function codes and unused opcodes so that the zero-result path is exercised. Operand values mix directed boundary cases (all ones, sign-bit patterns, equal operands) with pseudo-random words.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int OP_W = 6;
  localparam int FN_W = 11;

  localparam logic [OP_W-1:0] OPC_CMP   = 6'b000101;
  localparam logic [OP_W-1:0] OPC_EXT   = 6'b100100;
  localparam logic [OP_W-1:0] LOGIC_MSK = 6'b110100;
  localparam logic [OP_W-1:0] LOGIC_VAL = 6'b100000;

  localparam logic [FN_W-1:0] FN_CMP_S  = 11'h001;
  localparam logic [FN_W-1:0] FN_CMP_U  = 11'h003;
  localparam logic [FN_W-1:0] FN_SH_AR  = 11'h001;
  localparam logic [FN_W-1:0] FN_SH_CY  = 11'h021;
  localparam logic [FN_W-1:0] FN_SH_LO  = 11'h041;
  localparam logic [FN_W-1:0] FN_SX_B   = 11'h060;
  localparam logic [FN_W-1:0] FN_SX_H   = 11'h061;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_ARITH,
    SEL_LOGIC,
    SEL_SHIFT,
    SEL_SEXT
  } resSel_e;

  typedef enum logic [1:0] {
    TOP_ZERO,
    TOP_SIGN,
    TOP_CARRY
  } shTop_e;

  typedef struct packed {
    resSel_e    resSel;
    logic       invA;
    logic       useCarry;
    logic       cinConst;
    logic       cmpEn;
    logic       cmpSigned;
    logic [1:0] logicOp;
    shTop_e     shTop;
    logic       sextHalf;
    logic       carryWe;
  } aluCtl_t;

endpackage

// File: rtl/int_alu_ctrl.sv
module int_alu_ctrl
  import int_alu_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] func,
  output aluCtl_t         ctl
);

  logic isArith;
  logic isCmp;
  logic isLogic;

  assign isArith = (opcode[5:4] == 2'b00);
  assign isCmp   = (opcode == OPC_CMP) && ((func == FN_CMP_S) || (func == FN_CMP_U));
  assign isLogic = ((opcode & LOGIC_MSK) == LOGIC_VAL);

  always_comb begin
    ctl           = '0;
    ctl.resSel    = SEL_ZERO;
    ctl.shTop     = TOP_ZERO;
    if (isArith) begin
      ctl.resSel   = SEL_ARITH;
      ctl.invA     = opcode[0];
      ctl.cinConst = opcode[0];
      if (isCmp) begin
        ctl.cmpEn     = 1'b1;
        ctl.cmpSigned = (func == FN_CMP_S);
      end else begin
        ctl.useCarry = opcode[1];
        ctl.carryWe  = ~opcode[2];
      end
    end else if (isLogic) begin
      ctl.resSel  = SEL_LOGIC;
      ctl.logicOp = opcode[1:0];
    end else if (opcode == OPC_EXT) begin
      unique case (func)
        FN_SH_AR: begin
          ctl.resSel  = SEL_SHIFT;
          ctl.shTop   = TOP_SIGN;
          ctl.carryWe = 1'b1;
        end
        FN_SH_CY: begin
          ctl.resSel  = SEL_SHIFT;
          ctl.shTop   = TOP_CARRY;
          ctl.carryWe = 1'b1;
        end
        FN_SH_LO: begin
          ctl.resSel  = SEL_SHIFT;
          ctl.shTop   = TOP_ZERO;
          ctl.carryWe = 1'b1;
        end
        FN_SX_B: begin
          ctl.resSel   = SEL_SEXT;
          ctl.sextHalf = 1'b0;
        end
        FN_SX_H: begin
          ctl.resSel   = SEL_SEXT;
          ctl.sextHalf = 1'b1;
        end
        default: ctl.resSel = SEL_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/int_alu_dp.sv
module int_alu_dp
  import int_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  aluCtl_t        ctl,
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  input  logic           carryIn,
  output logic [W-1:0]   resVal,
  output logic           carryNext
);

  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  logic [W-1:0] aOp;
  logic         cin;
  logic [W:0]   sum;
  logic         cmpGt;
  logic         topBit;
  logic [W-1:0] arithVal;
  logic [W-1:0] logicVal;
  logic [W-1:0] shiftVal;
  logic [W-1:0] sextVal;

  assign aOp = ctl.invA ? ~opA : opA;
  assign cin = ctl.useCarry ? carryIn : ctl.cinConst;
  assign sum = {1'b0, aOp} + {1'b0, opB} + {{W{1'b0}}, cin};

  // carry set means B >= A unsigned; a sign mismatch flips the order
  assign cmpGt = ~sum[W] ^ (ctl.cmpSigned & (opA[W-1] ^ opB[W-1]));

  assign arithVal = ctl.cmpEn ? {cmpGt, sum[W-2:0]} : sum[W-1:0];

  always_comb begin
    unique case (ctl.logicOp)
      2'd0:    logicVal = opA | opB;
      2'd1:    logicVal = opA & opB;
      2'd2:    logicVal = opA ^ opB;
      default: logicVal = opA & ~opB;
    endcase
  end

  always_comb begin
    unique case (ctl.shTop)
      TOP_SIGN:  topBit = opA[W-1];
      TOP_CARRY: topBit = carryIn;
      default:   topBit = 1'b0;
    endcase
  end

  assign shiftVal = {topBit, opA[W-1:1]};

  assign sextVal = ctl.sextHalf
                 ? {{(W-HALF_W){opA[HALF_W-1]}}, opA[HALF_W-1:0]}
                 : {{(W-BYTE_W){opA[BYTE_W-1]}}, opA[BYTE_W-1:0]};

  always_comb begin
    unique case (ctl.resSel)
      SEL_ARITH: resVal = arithVal;
      SEL_LOGIC: resVal = logicVal;
      SEL_SHIFT: resVal = shiftVal;
      SEL_SEXT:  resVal = sextVal;
      default:   resVal = '0;
    endcase
  end

  always_comb begin
    if (!ctl.carryWe)                  carryNext = carryIn;
    else if (ctl.resSel == SEL_SHIFT)  carryNext = opA[0];
    else                               carryNext = sum[W];
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] func,
  input  logic [W-1:0]    opA,
  input  logic [W-1:0]    opB,
  input  logic            carryIn,
  output logic [W-1:0]    result,
  output logic            carryOut,
  output logic            carryWe
);

  aluCtl_t      ctl;
  logic [W-1:0] nextResult;
  logic         nextCarry;

  int_alu_ctrl u_ctrl (
    .opcode (opcode),
    .func   (func),
    .ctl    (ctl)
  );

  int_alu_dp #(.W(W)) u_dp (
    .ctl       (ctl),
    .opA       (opA),
    .opB       (opB),
    .carryIn   (carryIn),
    .resVal    (nextResult),
    .carryNext (nextCarry)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          result   <= '0;
          carryOut <= 1'b0;
          carryWe  <= 1'b0;
        end else begin
          result   <= nextResult;
          carryOut <= nextCarry;
          carryWe  <= ctl.carryWe;
        end
      end
    end else begin : g_comb
      assign result   = rstN ? nextResult : '0;
      assign carryOut = rstN & nextCarry;
      assign carryWe  = rstN & ctl.carryWe;
    end
  endgenerate

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import int_alu_pkg::*;
#(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic            clk,
  input logic            rstN,
  input logic [OP_W-1:0] opcode,
  input logic [FN_W-1:0] func,
  input logic [W-1:0]    opA,
  input logic [W-1:0]    opB,
  input logic            carryIn,
  input logic [W-1:0]    result,
  input logic            carryOut,
  input logic            carryWe
);

  logic [OP_W-1:0] opQ;
  logic [FN_W-1:0] fnQ;
  logic [W-1:0]    aQ;
  logic [W-1:0]    bQ;
  logic            cQ;
  logic            primed;

  generate
    if (REG_OUT) begin : g_obsReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          opQ    <= '0;
          fnQ    <= '0;
          aQ     <= '0;
          bQ     <= '0;
          cQ     <= 1'b0;
          primed <= 1'b0;
        end else begin
          opQ    <= opcode;
          fnQ    <= func;
          aQ     <= opA;
          bQ     <= opB;
          cQ     <= carryIn;
          primed <= 1'b1;
        end
      end
    end else begin : g_obsComb
      always_comb begin
        opQ    = opcode;
        fnQ    = func;
        aQ     = opA;
        bQ     = opB;
        cQ     = carryIn;
        primed = 1'b1;
      end
    end
  endgenerate

  logic isLogicQ;
  logic isShiftQ;
  logic isExtKnownQ;

  assign isLogicQ    = ((opQ & LOGIC_MSK) == LOGIC_VAL);
  assign isShiftQ    = (opQ == OPC_EXT) &&
                       (fnQ == FN_SH_AR || fnQ == FN_SH_CY || fnQ == FN_SH_LO);
  assign isExtKnownQ = isShiftQ || fnQ == FN_SX_B || fnQ == FN_SX_H;

  p_keep_carry_r3: assert property (@(posedge clk) disable iff (!rstN)
    (primed && opQ[5:4] == 2'b00 && opQ[2]) |-> (!carryWe && carryOut == cQ));

  p_cmp_signed_r4: assert property (@(posedge clk) disable iff (!rstN)
    (primed && opQ == OPC_CMP && fnQ == FN_CMP_S)
      |-> (!carryWe && result[W-1] == ($signed(aQ) > $signed(bQ))));

  p_cmp_unsigned_r5: assert property (@(posedge clk) disable iff (!rstN)
    (primed && opQ == OPC_CMP && fnQ == FN_CMP_U)
      |-> (!carryWe && result[W-1] == (aQ > bQ)));

  p_logic_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (primed && isLogicQ) |-> (!carryWe && carryOut == cQ));

  p_shift_carry_r7: assert property (@(posedge clk) disable iff (!rstN)
    (primed && isShiftQ)
      |-> (carryWe && carryOut == aQ[0] && result[W-2:0] == aQ[W-1:1]));

  p_sext_byte_r8: assert property (@(posedge clk) disable iff (!rstN)
    (primed && opQ == OPC_EXT && fnQ == FN_SX_B)
      |-> (!carryWe && result == {{(W-8){aQ[7]}}, aQ[7:0]}));

  p_unknown_ext_r9: assert property (@(posedge clk) disable iff (!rstN)
    (primed && opQ == OPC_EXT && !isExtKnownQ)
      |-> (result == '0 && !carryWe && carryOut == cQ));

  p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!primed) |-> (result == '0 && !carryWe && !carryOut));

endmodule

bind int_alu int_alu_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .opcode   (opcode),
  .func     (func),
  .opA      (opA),
  .opB      (opB),
  .carryIn  (carryIn),
  .result   (result),
  .carryOut (carryOut),
  .carryWe  (carryWe)
);

// File: tb/test_int_alu.sv
module test_int_alu;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int N_RANDOM   = 2000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  opcode = '0;
  logic [10:0] func = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [31:0] result;
  logic        carryOut;
  logic        carryWe;

  int checks = 0;
  int failures = 0;

  logic [31:0] expR;
  logic        expC;
  logic        expW;
  string       expTag;
  bit          pending = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu i_int_alu (
    .clk      (clk),
    .rstN     (rstN),
    .opcode   (opcode),
    .func     (func),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .result   (result),
    .carryOut (carryOut),
    .carryWe  (carryWe)
  );

  // behavioural reference: R1..R9 per operation class
  function automatic void refModel(
    input  logic [5:0]  o,
    input  logic [10:0] f,
    input  logic [31:0] x,
    input  logic [31:0] y,
    input  logic        c,
    output logic [31:0] r,
    output logic        co,
    output logic        we,
    output string       tag
  );
    logic [63:0] s;
    logic        cin;
    r = '0; co = c; we = 1'b0; tag = "R9";
    if (o[5:4] == 2'b00) begin
      if (o == 6'b000101 && (f == 11'd1 || f == 11'd3)) begin
        s = {32'h0, y} + {32'h0, ~x} + 64'd1;
        r = s[31:0];
        if (f == 11'd1) begin
          r[31] = ($signed(x) > $signed(y));
          tag = "R4";
        end else begin
          r[31] = (x > y);
          tag = "R5";
        end
      end else begin
        cin = o[1] ? c : o[0];
        if (o[0]) s = {32'h0, y} + {32'h0, ~x} + {63'h0, cin};
        else      s = {32'h0, x} + {32'h0, y}  + {63'h0, cin};
        r = s[31:0];
        if (!o[2]) begin
          co = s[32];
          we = 1'b1;
        end
        tag = o[2] ? "R3" : (o[0] ? "R2" : "R1");
      end
    end else if ((o & 6'b110100) == 6'b100000) begin
      tag = "R6";
      case (o[1:0])
        2'd0:    r = x | y;
        2'd1:    r = x & y;
        2'd2:    r = x ^ y;
        default: r = x & ~y;
      endcase
    end else if (o == 6'b100100) begin
      case (f)
        11'h001: begin r = {x[31], x[31:1]}; co = x[0]; we = 1'b1; tag = "R7"; end
        11'h021: begin r = {c, x[31:1]};     co = x[0]; we = 1'b1; tag = "R7"; end
        11'h041: begin r = {1'b0, x[31:1]};  co = x[0]; we = 1'b1; tag = "R7"; end
        11'h060: begin r = {{24{x[7]}}, x[7:0]};   tag = "R8"; end
        11'h061: begin r = {{16{x[15]}}, x[15:0]}; tag = "R8"; end
        default: tag = "R9";
      endcase
    end
  endfunction

  task automatic checkField(input string tag, input string name,
                            input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, name, act, exp);
    end
  endtask

  task automatic checkPending();
    if (pending) begin
      checkField(expTag, "result", result, expR);
      checkField(expTag, "carryOut", {31'h0, carryOut}, {31'h0, expC});
      checkField(expTag, "carryWe", {31'h0, carryWe}, {31'h0, expW});
    end
  endtask

  // drive at a falling edge; outputs checked one cycle later (R10 latency)
  task automatic apply(input logic [5:0] o, input logic [10:0] f,
                       input logic [31:0] x, input logic [31:0] y, input logic c);
    @(negedge clk);
    checkPending();
    opcode = o; func = f; opA = x; opB = y; carryIn = c;
    refModel(o, f, x, y, c, expR, expC, expW, expTag);
    pending = 1'b1;
  endtask

  function automatic logic [31:0] pickWord();
    case ($urandom_range(0, 5))
      0:       return 32'hFFFF_FFFF;
      1:       return 32'h8000_0000;
      2:       return 32'h7FFF_FFFF;
      3:       return 32'h0000_0000;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R10: outputs held at zero during reset
    opcode = 6'b000000; opA = 32'h1234_5678; opB = 32'h1111_1111; carryIn = 1'b1;
    repeat (3) @(negedge clk);
    checkField("R10", "reset result", result, 32'h0);
    checkField("R10", "reset carryWe", {31'h0, carryWe}, 32'h0);
    checkField("R10", "reset carryOut", {31'h0, carryOut}, 32'h0);
    rstN = 1'b1;

    // R1: add with wrap and carry-in use
    apply(6'b000000, 11'h0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1);
    apply(6'b000010, 11'h0, 32'h0000_0005, 32'h0000_0007, 1'b1);
    apply(6'b001010, 11'h0, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1);
    // R2: reverse subtract, borrow and no-borrow, carry-in replacing 1
    apply(6'b000001, 11'h0, 32'h0000_0009, 32'h0000_0003, 1'b1);
    apply(6'b001001, 11'h0, 32'h0000_0003, 32'h0000_0009, 1'b0);
    apply(6'b000011, 11'h0, 32'h0000_0003, 32'h0000_0009, 1'b0);
    // R3: K forms keep the flag
    apply(6'b000100, 11'h0, 32'hFFFF_FFFF, 32'h0000_0002, 1'b0);
    apply(6'b001111, 11'h0, 32'h0000_0001, 32'h0000_0000, 1'b1);
    apply(6'b000101, 11'h0, 32'h0000_0010, 32'h0000_0004, 1'b1);
    // R4/R5: compares with opposite signs and equal operands
    apply(6'b000101, 11'h1, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1);
    apply(6'b000101, 11'h3, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
    apply(6'b000101, 11'h1, 32'h0000_0001, 32'h8000_0000, 1'b0);
    apply(6'b000101, 11'h3, 32'h0000_0042, 32'h0000_0042, 1'b1);
    apply(6'b000101, 11'h1, 32'h8000_0000, 32'h8000_0000, 1'b0);
    // R6: all four logic selections
    for (int k = 0; k < 4; k++)
      apply(6'b100000 | 6'(k), 11'h0, 32'hF0F0_AAAA, 32'hFF00_5A5A, 1'b1);
    for (int k = 0; k < 4; k++)
      apply(6'b101000 | 6'(k), 11'h0, 32'h1234_5678, 32'hFFFF_8001, 1'b0);
    // R7: shifts with both carry values
    apply(6'b100100, 11'h001, 32'h8000_0001, 32'h0, 1'b0);
    apply(6'b100100, 11'h021, 32'h0000_0002, 32'h0, 1'b1);
    apply(6'b100100, 11'h041, 32'hFFFF_FFFF, 32'h0, 1'b1);
    // R8: sign extension at the sign boundaries
    apply(6'b100100, 11'h060, 32'h1234_5680, 32'h0, 1'b0);
    apply(6'b100100, 11'h060, 32'hFFFF_FF7F, 32'h0, 1'b0);
    apply(6'b100100, 11'h061, 32'h0000_8000, 32'h0, 1'b1);
    apply(6'b100100, 11'h061, 32'hABCD_7FFF, 32'h0, 1'b1);
    // R9: unknown function and unused opcode
    apply(6'b100100, 11'h022, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    apply(6'b100100, 11'h401, 32'h0000_0003, 32'h0, 1'b0);
    apply(6'b111111, 11'h000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);

    for (int n = 0; n < N_RANDOM; n++) begin
      logic [5:0]  o;
      logic [10:0] f;
      int          sel;
      sel = $urandom_range(0, 5);
      case (sel)
        0, 1: begin o = {3'b000, 3'($urandom_range(0, 7))}; f = 11'h0; end
        2: begin
          o = 6'b000101;
          case ($urandom_range(0, 2)) 0: f = 11'h1; 1: f = 11'h3; default: f = 11'h0; endcase
        end
        3: begin o = {2'b10, 1'($urandom_range(0, 1)), 1'b0, 2'($urandom_range(0, 3))}; f = 11'($urandom()); end
        4: begin
          o = 6'b100100;
          case ($urandom_range(0, 5))
            0: f = 11'h001; 1: f = 11'h021; 2: f = 11'h041;
            3: f = 11'h060; 4: f = 11'h061; default: f = 11'($urandom());
          endcase
        end
        default: o = 6'($urandom());
      endcase
      if (sel == 5) f = 11'($urandom());
      apply(o, f, pickWord(), pickWord(), 1'($urandom_range(0, 1)));
    end

    @(negedge clk);
    checkPending();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule